// File: doc/BRIEF.md
# MDIO Management Bus Master

This block runs an MDIO management bus as its master. It generates the MDC clock and drives or releases the MDIO data line. It serves both Clause 22 and Clause 45 management frames. Software sees a single 32-bit command/status word. Writing that word while the engine is idle loads its fields. If bit 31 is set in the same write, one frame starts. Bit 31 reads back as busy until the last bit of the frame has gone out. After a read frame, the 16 bits returned by the PHY sit in the low half of the same word.

The frame-type and opcode fields are placed on the wire exactly as software writes them. A frame is built MSB first from the following parts, in this order:
- 32 preamble ones
- the 2-bit start code
- the 2-bit opcode
- the 5-bit PHY address
- the 5-bit register or device address
- a 2-bit turnaround
- 16 data bits

A Clause 45 access takes two frames. The first is an address frame that carries the register address in the data bits. The second is a separate write or read frame. MDC runs at the system clock divided by `2*HALF_DIV`. The default of 10 gives 2.5 MHz from a 50 MHz clock.

Top module: `mdio_master`

## Requirements
- R1: Reading the word returns busy in bit 31 and its inverse (ready) in bit 30. Bits 29:16 return the last accepted fields: 29:25 register/device address, 24:20 PHY address, 19:18 command, 17:16 start code.
- R2: A write with bit 31 set while idle starts a frame. Busy is high from the next cycle until the 64th bit completes, then clears on its own.
- R3: Each frame is 64 bits sent MSB first: 32 ones, start code, command, PHY address, register/device address, turnaround, then 16 data bits. MDIO changes only while MDC is low and is stable across MDC high.
- R4: Start code 1 selects Clause 22, with command 1 as a write and command 2 as a read. Both fields are sent unchanged as frame bits.
- R5: Start code 0 selects Clause 45. Command 0 is an address frame, 1 a write, 2 a read with post-increment, and 3 a read. The address frame carries bits 15:0 as its data bits.
- R6: Any frame whose command bit 19 is set is a read. MDIO output enable is low from the first turnaround bit to the end of the frame. MDIO is sampled on MDC rising edges, and the 16 sampled bits are readable in bits 15:0 once busy clears.
- R7: Any frame whose command bit 19 is clear is a write-type frame. Output enable is high for all 64 bits, the turnaround is driven as 1 then 0, and bits 15:0 read back the written value.
- R8: Writes to the word while busy is set are ignored. The frame in flight and the stored fields are unchanged.
- R9: A write with bit 31 clear while idle loads the fields and data without starting a frame.
- R10: MDC has a period of 2*HALF_DIV clock cycles during a frame and is low while idle. Output enable is low while idle.
- R11: Synchronous reset clears busy, the fields and the data bits. After reset, a read of an absent PHY (MDIO pulled high) returns 0xFFFF, not stale data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe for the command/status word |
| wr_data | input | 32 | Value written to the command/status word |
| rd_data | output | 32 | Current command/status word |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO value driven by the master |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO value seen on the line |

## Verification
On every cycle the assertions check these properties:
- ready is the inverse of busy;
- MDC is low and output enable is off whenever the engine is idle;
- busy rises only after a start write;
- the fields hold still while busy;
- MDIO stays stable through each MDC high phase;
- reset leaves the word in its cleared state.

Only the bench scenarios can show the rest. These are the exact bit order of each Clause 22 and Clause 45 frame, the turnaround and output-enable pattern of reads against writes, the data captured from a responder, the MDC period, and the clearing of stale read data after reset.

// File: rtl/mdio_master.sv
module mdio_master #(
  parameter int HALF_DIV = 10
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  localparam int CW = $clog2(HALF_DIV + 1);
  localparam int FRAME = 64;
  localparam int TA_POS = 46;
  localparam int DATA_POS = 48;

  logic              busy, is_rd, mdc_q;
  logic [13:0]       cfg;
  logic [15:0]       dat;
  logic [FRAME-1:0]  sh;
  logic [5:0]        bitn;
  logic [CW-1:0]     cnt;

  wire tick = (cnt == CW'(HALF_DIV - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      is_rd <= 1'b0;
      mdc_q <= 1'b0;
      cfg   <= '0;
      dat   <= '0;
      sh    <= '0;
      bitn  <= '0;
      cnt   <= '0;
    end else if (wr_en && !busy) begin
      cfg <= wr_data[29:16];
      dat <= wr_data[15:0];
      if (wr_data[31]) begin
        busy  <= 1'b1;
        is_rd <= wr_data[19];
        sh    <= {32'hFFFF_FFFF, wr_data[17:16], wr_data[19:18],
                  wr_data[24:20], wr_data[29:25], 2'b10, wr_data[15:0]};
        bitn  <= '0;
        cnt   <= '0;
        mdc_q <= 1'b0;
      end
    end else if (busy) begin
      if (tick) begin
        cnt   <= '0;
        mdc_q <= ~mdc_q;
        if (!mdc_q) begin
          if (is_rd && bitn >= 6'(DATA_POS))
            dat <= {dat[14:0], mdio_i};
        end else if (bitn == 6'(FRAME - 1)) begin
          busy <= 1'b0;
        end else begin
          bitn <= bitn + 1'b1;
          sh   <= {sh[FRAME-2:0], 1'b0};
        end
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign rd_data = {busy, ~busy, cfg, dat};
  assign mdc     = mdc_q;
  assign mdio_o  = sh[FRAME-1];
  assign mdio_oe = busy & ~(is_rd & (bitn >= 6'(TA_POS)));
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk (
  input logic        clk,
  input logic        rst,
  input logic        wr_en,
  input logic [31:0] wr_data,
  input logic [31:0] rd_data,
  input logic        mdc,
  input logic        mdio_o,
  input logic        mdio_oe
);
  a_r1_ready_inverse: assert property (@(posedge clk) disable iff (rst)
    rd_data[30] == !rd_data[31]);

  a_r2_busy_needs_start: assert property (@(posedge clk) disable iff (rst)
    $rose(rd_data[31]) |-> $past(wr_en && wr_data[31]));

  a_r10_idle_mdc_low: assert property (@(posedge clk) disable iff (rst)
    !rd_data[31] |-> (!mdc && !mdio_oe));

  a_r8_fields_hold: assert property (@(posedge clk) disable iff (rst)
    (rd_data[31] && $past(rd_data[31])) |-> $stable(rd_data[29:16]));

  a_r3_mdio_stable_high: assert property (@(posedge clk) disable iff (rst)
    (mdc && $past(mdc)) |-> $stable(mdio_o));

  a_r11_reset_clears: assert property (@(posedge clk)
    rst |=> (rd_data == 32'h4000_0000 && !mdc && !mdio_oe));
endmodule

bind mdio_master mdio_master_chk u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
  .rd_data(rd_data), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
);

// File: tb/sim_mdio_master.sv
module sim_mdio_master;
  localparam int CLK_P = 10;
  localparam int HALF = 2;
  localparam int NV = 6;
  localparam logic [31:0] CMDS [NV] = '{32'h8655_A5C3, 32'h85F9_0000, 32'hBC10_1234,
                                        32'hBC14_BEEF, 32'hBC1C_0000, 32'hBC18_8001};
  localparam logic [15:0] RESP [NV] = '{16'h0000, 16'h7500, 16'h0000,
                                        16'h0000, 16'h0F0F, 16'h8001};

  logic clk = 0, rst = 1, wr_en = 0, mdio_i = 1;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic mdc, mdio_o, mdio_oe;
  int total = 0, fails = 0, k = 0;
  logic [15:0] resp = '0;
  logic [63:0] cap_o, cap_oe;
  time t0, t1;

  mdio_master #(.HALF_DIV(HALF)) u0 (.clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i));

  always #(CLK_P/2) clk = ~clk;

  always @(posedge mdc) begin
    if (k == 0) t0 = $time;
    if (k == 1) t1 = $time;
    if (k < 64) begin
      cap_o[63-k]  = mdio_o;
      cap_oe[63-k] = mdio_oe;
    end
    k = k + 1;
  end

  always @(negedge mdc)
    mdio_i = (k >= 48 && k <= 63) ? resp[63-k] : 1'b1;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_frame(input logic [31:0] c);
    return {32'hFFFF_FFFF, c[17:16], c[19:18], c[24:20], c[29:25], 2'b10, c[15:0]};
  endfunction

  function automatic logic [63:0] exp_oe(input logic [31:0] c);
    return c[19] ? {{46{1'b1}}, 18'b0} : {64{1'b1}};
  endfunction

  task automatic wr(input logic [31:0] v);
    @(negedge clk); wr_en = 1; wr_data = v;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic wait_idle;
    for (int i = 0; i < 5000 && rd_data[31]; i++) @(negedge clk);
  endtask

  task automatic run(input logic [31:0] c, input logic [15:0] r, input string req);
    resp = r; k = 0;
    wr(c);
    chk(rd_data[31] == 1'b1, {"R2 busy after start ", req}, {63'b0, rd_data[31]}, 64'd1);
    wait_idle();
    chk(rd_data[31] == 1'b0, {"R2 busy cleared ", req}, {63'b0, rd_data[31]}, 64'd0);
    chk(((cap_o ^ exp_frame(c)) & exp_oe(c)) == 0, {"R3 frame bits ", req}, cap_o, exp_frame(c));
    chk(cap_oe == exp_oe(c), {(c[19] ? "R6" : "R7"), " output enable ", req}, cap_oe, exp_oe(c));
    chk(rd_data[15:0] == (c[19] ? r : c[15:0]), {(c[19] ? "R6" : "R7"), " data ", req},
        {48'b0, rd_data[15:0]}, {48'b0, (c[19] ? r : c[15:0])});
    chk(rd_data[30:16] == {1'b1, c[29:16]}, {"R1 readback ", req},
        {49'b0, rd_data[30:16]}, {49'b0, 1'b1, c[29:16]});
  endtask

  initial begin
    #(CLK_P * 200000);
    fails++; total++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    chk(rd_data == 32'h4000_0000 && !mdc && !mdio_oe, "R11 reset state",
        {32'b0, rd_data}, 64'h4000_0000);

    for (int i = 0; i < NV; i++)
      run(CMDS[i], RESP[i], (i < 2) ? "R4 clause22" : "R5 clause45");

    chk(t1 - t0 == 2 * HALF * CLK_P, "R10 MDC period", t1 - t0, 2 * HALF * CLK_P);

    // R8: a write during a frame is ignored
    resp = 16'h0; k = 0;
    wr(32'h8655_1111);
    repeat (20) @(negedge clk);
    wr(32'h8A2A_2222);
    wait_idle();
    chk(cap_o == exp_frame(32'h8655_1111), "R8 frame unchanged", cap_o, exp_frame(32'h8655_1111));
    chk(rd_data[29:0] == 30'h0655_1111, "R8 fields unchanged",
        {34'b0, rd_data[29:0]}, 64'h0655_1111);

    // R9: idle write without bit 31
    wr(32'h0A2A_3333);
    repeat (30) @(negedge clk);
    chk(rd_data == 32'h4A2A_3333 && !mdc, "R9 load without start",
        {31'b0, mdc, rd_data}, 64'h4A2A_3333);

    // R11: stale read data cleared by reset, absent PHY reads ones
    run(32'h85F9_0000, 16'h7500, "R6 pre-reset read");
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    chk(rd_data[15:0] == 16'h0, "R11 data cleared", {48'b0, rd_data[15:0]}, 64'h0);
    resp = 16'hFFFF; k = 0;
    wr(32'h8409_0000);
    wait_idle();
    chk(rd_data[15:0] == 16'hFFFF, "R11 absent PHY", {48'b0, rd_data[15:0]}, 64'hFFFF);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule